// File: doc/BRIEF.md
# Completion Interrupt Coalescing Unit

This unit sits next to a job completion queue and decides when the host should be interrupted. Each finished job arrives as a one-cycle pulse. Rather than interrupting once per job, the unit can batch completions. It raises a level interrupt when enough jobs have piled up or when the oldest unserviced completion has waited long enough. The interrupt then stays high until software acknowledges it with a clear pulse.

Software supplies three settings: an enable for batching, an 8-bit job-count limit and a 16-bit wait limit. The wait limit is measured in ticks, and one tick is 64 clock cycles. When batching is off, or the wait limit is zero, the unit falls back to one interrupt per completed job. A count limit of zero is treated as a limit of one.

Top module: `irq_coalescer`

## Requirements
- R1: After reset, `irq_o` is low.
- R2: With `coal_en_i` low, a `job_done_i` pulse sampled at clock edge k makes `irq_o` high right after edge k.
- R3: With `coal_en_i` high and `tmr_limit_i` equal to 0, a `job_done_i` pulse sampled at edge k makes `irq_o` high right after edge k, exactly as in R2.
- R4: With batching active and `cnt_limit_i` = N (1 to 255), `irq_o` stays low through the Nth completion edge and goes high one edge after it.
- R5: A `cnt_limit_i` of 0 behaves like 1, so `irq_o` rises one edge after the first completion.
- R6: With batching active and `tmr_limit_i` = T, `irq_o` rises 64*T+1 edges after the first completion that follows a clear, whatever the count limit. Later completions do not restart the wait.
- R7: `irq_o` stays high until `irq_clr_i` is sampled. It is low after that edge, and the clear empties the pending count, the wait timer and the 64-cycle prescaler.
- R8: A completion sampled on the same edge as `irq_clr_i` is counted toward the next interrupt. With a limit of 1, `irq_o` rises again one edge after the clear.
- R9: The limits and the enable are compared live. Lowering `cnt_limit_i` to or below the pending count makes `irq_o` rise on the next edge.
- R10: The pending completion count saturates at 255 instead of wrapping, so `irq_o` stays high while completions continue past 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| job_done_i | input | 1 | One-cycle pulse per finished job |
| coal_en_i | input | 1 | Batching enable |
| cnt_limit_i | input | 8 | Completion count limit (0 acts as 1) |
| tmr_limit_i | input | 16 | Wait limit in 64-cycle ticks (0 selects per-job mode) |
| irq_clr_i | input | 1 | Software acknowledge pulse |
| irq_o | output | 1 | Sticky level interrupt |

## Verification
In per-job mode, `irq_o` is due just after the edge that samples the completion. On the count path, the registered pending count is compared, so `irq_o` follows one edge after the threshold-reaching completion. The wait path needs 64*T edges to accumulate ticks and one more edge to register the interrupt. The bench drives and samples on the falling edge and counts falling edges from the sampling edge. Each check therefore lands on the exact cycle, and the cycle just before it is checked to be still low.

// File: rtl/icu_pkg.sv
// Shared sizing for the interrupt coalescing unit.
// Assumes: the count field is 8 bits, the timer field 16 bits, prescale by 64.
package icu_pkg;
    localparam int unsigned ICU_CNT_W   = 8;
    localparam int unsigned ICU_TMR_W   = 16;
    localparam int unsigned ICU_PRE_DIV = 64;
endpackage

// File: rtl/icu_prescaler.sv
// Tick generator: emits one tick every DIV cycles while run is high.
// Assumes: restart has priority and returns the phase to zero.
module icu_prescaler #(
    parameter int unsigned DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    // tick on the last phase of a running period
    assign tick_o = run_i && !restart_i && (phase_q == LAST);

    // phase counter advances while running, wraps at DIV
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            phase_q <= '0;
        end else if (run_i) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/icu_pend_counter.sv
// Pending completion counter: counts jobs since the last clear.
// Assumes: a completion in the clear cycle starts the new count at one.
module icu_pend_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         done_i,
    input  logic         clr_i,
    output logic [W-1:0] pend_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] pend_q;

    // saturating count, reseeded by clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (clr_i) begin
            pend_q <= done_i ? W'(1) : '0;
        end else if (done_i && pend_q != MAXV) begin
            pend_q <= pend_q + 1'b1;
        end
    end

    assign pend_o = pend_q;

    AST_PEND_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == MAXV && done_i && !clr_i) |=> (pend_q == MAXV)); // R10
    AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !done_i) |=> (pend_q == '0)); // R7
endmodule

// File: rtl/icu_wait_timer.sv
// Wait timer: idle until the first completion after a clear, then counts
// prescaler ticks until cleared. Later completions do not restart it.
module icu_wait_timer #(
    parameter int unsigned W   = 16,
    parameter int unsigned DIV = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         done_i,
    input  logic         clr_i,
    output logic         active_o,
    output logic [W-1:0] ticks_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic         active_q;
    logic [W-1:0] ticks_q;
    logic         start;
    logic         restart;
    logic         tick;

    assign start   = done_i && !active_q && !clr_i;
    assign restart = clr_i || start;

    icu_prescaler #(.DIV(DIV)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (active_q),
        .restart_i (restart),
        .tick_o    (tick)
    );

    // active flag: armed by a completion, dropped by a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else if (clr_i) begin
            active_q <= done_i;
        end else if (done_i) begin
            active_q <= 1'b1;
        end
    end

    // tick count since arming, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ticks_q <= '0;
        end else if (tick && ticks_q != MAXV) begin
            ticks_q <= ticks_q + 1'b1;
        end
    end

    assign active_o = active_q;
    assign ticks_o  = ticks_q;

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && done_i && !clr_i) |=> (ticks_q >= $past(ticks_q))); // R6
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !done_i) |=> (!active_q && ticks_q == '0)); // R7
endmodule

// File: rtl/irq_coalescer.sv
// Completion interrupt coalescing top. Combines the pending count and the
// wait timer against live limits and holds a sticky interrupt.
// Assumes: job_done_i and irq_clr_i are single-cycle pulses, sync to clk.
module irq_coalescer
    import icu_pkg::*;
#(
    parameter int unsigned CNT_W   = ICU_CNT_W,
    parameter int unsigned TMR_W   = ICU_TMR_W,
    parameter int unsigned PRE_DIV = ICU_PRE_DIV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             job_done_i,
    input  logic             coal_en_i,
    input  logic [CNT_W-1:0] cnt_limit_i,
    input  logic [TMR_W-1:0] tmr_limit_i,
    input  logic             irq_clr_i,
    output logic             irq_o
);
    logic [CNT_W-1:0] pend;
    logic [CNT_W-1:0] eff_limit;
    logic [TMR_W-1:0] ticks;
    logic             active;
    logic             bypass;
    logic             fire_cnt;
    logic             fire_tmr;
    logic             fire;
    logic             irq_q;

    icu_pend_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_i (job_done_i),
        .clr_i  (irq_clr_i),
        .pend_o (pend)
    );

    icu_wait_timer #(.W(TMR_W), .DIV(PRE_DIV)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (job_done_i),
        .clr_i    (irq_clr_i),
        .active_o (active),
        .ticks_o  (ticks)
    );

    // limit decode and race between the two thresholds
    always_comb begin
        bypass    = !coal_en_i || (tmr_limit_i == '0);
        eff_limit = (cnt_limit_i == '0) ? CNT_W'(1) : cnt_limit_i;
        fire_cnt  = (pend != '0) && (pend >= eff_limit);
        fire_tmr  = active && (ticks >= tmr_limit_i);
        if (bypass) begin
            fire = job_done_i || (pend != '0);
        end else begin
            fire = fire_cnt || fire_tmr;
        end
    end

    // sticky interrupt, clear wins
    always_ff @(posedge clk) begin
        if (!rst_n || irq_clr_i) begin
            irq_q <= 1'b0;
        end else if (fire) begin
            irq_q <= 1'b1;
        end
    end

    assign irq_o = irq_q;

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr_i |=> !irq_o); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr_i) |=> irq_o); // R7
    AST_BYPASS_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!coal_en_i && job_done_i && !irq_clr_i) |=> irq_o); // R2
    AST_CNT_REACHED: assert property (@(posedge clk) disable iff (!rst_n)
        (coal_en_i && tmr_limit_i != '0 && pend != '0 && pend >= cnt_limit_i
         && !irq_clr_i) |=> irq_o); // R4
endmodule

// File: tb/irq_coalescer_test.sv
module irq_coalescer_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        job_done_i = 1'b0;
    logic        coal_en_i = 1'b0;
    logic [7:0]  cnt_limit_i = '0;
    logic [15:0] tmr_limit_i = '0;
    logic        irq_clr_i = 1'b0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    irq_coalescer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .job_done_i  (job_done_i),
        .coal_en_i   (coal_en_i),
        .cnt_limit_i (cnt_limit_i),
        .tmr_limit_i (tmr_limit_i),
        .irq_clr_i   (irq_clr_i),
        .irq_o       (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic exp, input string tag);
        checks++;
        if (irq_o !== exp) begin
            errors++;
            $display("FAIL %s irq_o actual=%b expected=%b", tag, irq_o, exp);
        end
    endtask

    // one completion: sampled at the next posedge, returns at the negedge after
    task automatic pulse();
        job_done_i = 1'b1;
        @(negedge clk);
        job_done_i = 1'b0;
    endtask

    task automatic clear();
        irq_clr_i = 1'b1;
        @(negedge clk);
        irq_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        chk(1'b0, "R1 reset");
    endtask

    task automatic t_bypass_en();
        coal_en_i = 0; cnt_limit_i = 8'd10; tmr_limit_i = 16'd50;
        clear();
        chk(1'b0, "R2 before");
        pulse();
        chk(1'b1, "R2 disabled per-job");
        clear();
        chk(1'b0, "R7 clear drops");
    endtask

    task automatic t_bypass_tmr0();
        coal_en_i = 1; cnt_limit_i = 8'd10; tmr_limit_i = 16'd0;
        clear();
        pulse();
        chk(1'b1, "R3 timer zero per-job");
        clear();
    endtask

    task automatic t_count(input int n);
        coal_en_i = 1; cnt_limit_i = 8'(n); tmr_limit_i = 16'd1000;
        clear();
        for (int i = 0; i < n - 1; i++) begin
            pulse();
            @(negedge clk);
        end
        chk(1'b0, "R4 below limit");
        pulse();
        chk(1'b0, "R4 limit edge");
        @(negedge clk);
        chk(1'b1, "R4 one edge after limit");
        repeat (5) @(negedge clk);
        chk(1'b1, "R7 sticky");
        clear();
        chk(1'b0, "R7 cleared");
        @(negedge clk);
        chk(1'b0, "R7 count emptied");
    endtask

    task automatic t_count0();
        coal_en_i = 1; cnt_limit_i = 8'd0; tmr_limit_i = 16'd1000;
        clear();
        pulse();
        chk(1'b0, "R5 same edge");
        @(negedge clk);
        chk(1'b1, "R5 zero acts as one");
        clear();
    endtask

    task automatic t_timer();
        coal_en_i = 1; cnt_limit_i = 8'd200; tmr_limit_i = 16'd2;
        clear();
        pulse();
        repeat (50) @(negedge clk);
        pulse();
        repeat (77) @(negedge clk);
        chk(1'b0, "R6 before 64*T+1");
        @(negedge clk);
        chk(1'b1, "R6 timer fires");
        clear();
        repeat (140) @(negedge clk);
        chk(1'b0, "R7 timer idle after clear");
    endtask

    task automatic t_clr_same();
        coal_en_i = 1; cnt_limit_i = 8'd1; tmr_limit_i = 16'd1000;
        clear();
        pulse();
        @(negedge clk);
        chk(1'b1, "R8 setup");
        irq_clr_i = 1'b1; job_done_i = 1'b1;
        @(negedge clk);
        irq_clr_i = 1'b0; job_done_i = 1'b0;
        chk(1'b0, "R8 clear edge");
        @(negedge clk);
        chk(1'b1, "R8 completion kept");
        clear();
    endtask

    task automatic t_lower();
        coal_en_i = 1; cnt_limit_i = 8'd10; tmr_limit_i = 16'd1000;
        clear();
        repeat (3) begin
            pulse();
            @(negedge clk);
        end
        chk(1'b0, "R9 above pending");
        cnt_limit_i = 8'd2;
        @(negedge clk);
        chk(1'b1, "R9 lowered fires next edge");
        clear();
    endtask

    task automatic t_sat();
        coal_en_i = 1; cnt_limit_i = 8'd255; tmr_limit_i = 16'hFFFF;
        clear();
        for (int i = 0; i < 254; i++) pulse();
        @(negedge clk);
        chk(1'b0, "R10 below 255");
        for (int i = 0; i < 40; i++) pulse();
        @(negedge clk);
        chk(1'b1, "R10 saturated count keeps irq");
        clear();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog irq_o actual=%b expected=done", irq_o);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass_en();
        t_bypass_tmr0();
        t_count(1);
        t_count(4);
        t_count0();
        t_timer();
        t_clr_same();
        t_lower();
        t_sat();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule